// File: doc/BRIEF.md
# Filtered External Interrupt Controller

This block gathers fourteen asynchronous interrupt lines from outside the chip and turns them into two grouped interrupt requests for a downstream vector controller. Every line is brought into the clock domain through a two-stage synchroniser. It can then pass through a counting glitch filter. Its rising edges, its falling edges, or both, latch a per-line pending flag.

All fourteen filters share one sampling-rate divider. Each line has its own acceptance threshold. A line's filtered level changes only once the synchronised input has disagreed with it on enough consecutive sampling ticks.

Software reaches the block through a flat register port with a single write strobe and a combinational read path. The pending flags are cleared by writing ones to them. Lines 0 to 7 share request output 0, and lines 8 to 13 share request output 1. A line takes part in its group only while its request enable is set.

Top module: `xirq_filter_ctrl`

## Requirements
- R1: After reset, every configuration register, every pending flag and both request outputs read zero. Input levels present at reset do not produce a flag once edge enables are turned on.
- R2: With the filter off, a line whose rise enable (address 0, bit n) is set latches its flag on the fourth rising clock edge after its input goes from 0 to 1. The flag is still clear on the third edge.
- R3: A line whose fall enable (address 1, bit n) is set latches its flag on a 1-to-0 transition. With both enables set, either direction latches the flag.
- R4: A line with both its rise enable and its fall enable clear never sets its flag.
- R5: Request output bit 0 is the OR of (flag AND request enable) over lines 0–7. Output bit 1 is the same OR over lines 8–13. Request enables live at address 2, bit n.
- R6: Flags read at address 5, bit n. Writing 1 to a bit there clears that flag, and writing 0 leaves it untouched.
- R7: If an edge sets a flag in the same cycle that a clear is written to it, the flag stays set.
- R8: When a line's filter enable (address 3, bit n) is clear, edge detection follows the synchronised input directly.
- R9: The filter ticks once every (P+1) clocks, where P is the prescaler at address 4, bits 3:0. A filtered line changes level after its input has differed on L consecutive ticks, where L is the line's limit and a limit of 0 counts as 1. A tick on which the input agrees resets the run.
- R10: Register map:
  - 0: rise enables
  - 1: fall enables
  - 2: request enables
  - 3: filter enables
  - 4: prescaler, bits 3:0
  - 5: flags
  - 8+n: limit of line n, bits 3:0

  Enable and flag registers use bits 13:0. Bits that are not implemented, and addresses that are not mapped, read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_in | input | 14 | Asynchronous external interrupt lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_out | output | 2 | Grouped interrupt requests |

## Verification
The bench builds the block with its default parameters: fourteen lines, a group split at line 8, 4-bit limits and a 4-bit prescaler. The ordinary register port can therefore reach every line, every threshold from 0 to 15 and every tick period from 1 to 16 clocks.

A prescaler of 3 is used for the filter tests, so each tick covers four clocks. With that setting, a pulse of seven clocks holds at most two ticks and can be rejected exactly against a limit of 3. A four-clock pulse holds exactly one tick and is accepted against a limit of 0. The second request output is reached through line 9.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  // register addresses
  localparam int A_RISE = 0;
  localparam int A_FALL = 1;
  localparam int A_REQ  = 2;
  localparam int A_FILT = 3;
  localparam int A_PRE  = 4;
  localparam int A_FLAG = 5;
  localparam int A_LIM0 = 8;

  // filter acceptance: a limit of zero behaves as one
  function automatic bit limit_met(int unsigned seen, int unsigned lim);
    return seen >= ((lim == 0) ? 1 : lim);
  endfunction

  // prescaler phase: wraps when it has reached the setting
  function automatic bit phase_done(int unsigned phase, int unsigned setting);
    return phase >= setting;
  endfunction
endpackage

// File: rtl/xirq_tick.sv
module xirq_tick #(
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] presc,
  output logic             tick
);
  logic [PRE_W-1:0] phase;

  assign tick = xirq_pkg::phase_done(int'(phase), int'(presc));

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= '0;
    else if (tick) phase <= '0;
    else phase <= phase + PRE_W'(1);
  end
endmodule

// File: rtl/xirq_chan.sv
module xirq_chan #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin,
  input  logic             warm_done,
  input  logic             tick,
  input  logic             filt_en,
  input  logic [CNT_W-1:0] lim,
  output logic             level,
  output logic             rise,
  output logic             fall
);
  logic             s1, s2, prev;
  logic [CNT_W-1:0] run;
  logic [CNT_W:0]   run_nx;
  logic             differ;

  assign run_nx = {1'b0, run} + (CNT_W+1)'(1);
  assign differ = s2 ^ level;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1    <= 1'b0;
      s2    <= 1'b0;
      level <= 1'b0;
      prev  <= 1'b0;
      run   <= '0;
    end else begin
      s1   <= pin;
      s2   <= s1;
      prev <= level;
      if (!warm_done) begin
        // level and history follow the synchroniser: no edge from reset
        level <= s2;
        prev  <= s2;
        run   <= '0;
      end else if (!filt_en) begin
        level <= s2;
        run   <= '0;
      end else if (tick) begin
        if (!differ) run <= '0;
        else if (xirq_pkg::limit_met(int'(run_nx), int'(lim))) begin
          level <= s2;
          run   <= '0;
        end else begin
          run <= run_nx[CNT_W-1:0];
        end
      end
    end
  end

  assign rise = level & ~prev;
  assign fall = ~level & prev;
endmodule

// File: rtl/xirq_regs.sv
module xirq_regs #(
  parameter int NCH    = 14,
  parameter int CNT_W  = 4,
  parameter int PRE_W  = 4,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [DATA_W-1:0]         reg_wdata,
  output logic [DATA_W-1:0]         reg_rdata,
  input  logic [NCH-1:0]            set_vec,
  output logic [NCH-1:0]            clr_vec,
  output logic [NCH-1:0]            flags,
  output logic [NCH-1:0]            rise_en,
  output logic [NCH-1:0]            fall_en,
  output logic [NCH-1:0]            ien,
  output logic [NCH-1:0]            fen,
  output logic [PRE_W-1:0]          presc,
  output logic [NCH-1:0][CNT_W-1:0] lim
);
  import xirq_pkg::*;

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata[DATA_W-1:NCH];

  function automatic logic hit(logic [ADDR_W-1:0] a, int where);
    return a == ADDR_W'(where);
  endfunction

  assign clr_vec = (reg_wr && hit(reg_addr, A_FLAG)) ? reg_wdata[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rise_en <= '0;
      fall_en <= '0;
      ien     <= '0;
      fen     <= '0;
      presc   <= '0;
      flags   <= '0;
      lim     <= '0;
    end else begin
      flags <= (flags & ~clr_vec) | set_vec;  // set wins over clear
      if (reg_wr) begin
        if (hit(reg_addr, A_RISE)) rise_en <= reg_wdata[NCH-1:0];
        if (hit(reg_addr, A_FALL)) fall_en <= reg_wdata[NCH-1:0];
        if (hit(reg_addr, A_REQ))  ien     <= reg_wdata[NCH-1:0];
        if (hit(reg_addr, A_FILT)) fen     <= reg_wdata[NCH-1:0];
        if (hit(reg_addr, A_PRE))  presc   <= reg_wdata[PRE_W-1:0];
        for (int i = 0; i < NCH; i++)
          if (hit(reg_addr, A_LIM0 + i)) lim[i] <= reg_wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit(reg_addr, A_RISE)) reg_rdata[NCH-1:0]   = rise_en;
    if (hit(reg_addr, A_FALL)) reg_rdata[NCH-1:0]   = fall_en;
    if (hit(reg_addr, A_REQ))  reg_rdata[NCH-1:0]   = ien;
    if (hit(reg_addr, A_FILT)) reg_rdata[NCH-1:0]   = fen;
    if (hit(reg_addr, A_PRE))  reg_rdata[PRE_W-1:0] = presc;
    if (hit(reg_addr, A_FLAG)) reg_rdata[NCH-1:0]   = flags;
    for (int i = 0; i < NCH; i++)
      if (hit(reg_addr, A_LIM0 + i)) reg_rdata[CNT_W-1:0] = lim[i];
  end
endmodule

// File: rtl/xirq_filter_ctrl.sv
module xirq_filter_ctrl #(
  parameter int NCH    = 14,
  parameter int GRP0   = 8,
  parameter int CNT_W  = 4,
  parameter int PRE_W  = 4,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    ext_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [1:0]        irq_out
);
  localparam int WARM = 3;  // cycles for the synchroniser to fill

  logic [NCH-1:0]            set_vec, clr_vec, flags;
  logic [NCH-1:0]            rise_en, fall_en, ien, fen;
  logic [NCH-1:0]            rise_v, fall_v, level_v;
  logic [NCH-1:0]            pend;
  logic [PRE_W-1:0]          presc;
  logic [NCH-1:0][CNT_W-1:0] lim;
  logic                      tick;
  logic [1:0]                warm;
  logic                      warm_done;
  logic                      unused_level;

  assign warm_done = (warm == 2'(WARM));
  assign unused_level = ^level_v;

  always_ff @(posedge clk) begin
    if (!rst_n) warm <= '0;
    else if (!warm_done) warm <= warm + 2'd1;
  end

  xirq_regs #(
    .NCH(NCH), .CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .set_vec(set_vec),
    .clr_vec(clr_vec), .flags(flags), .rise_en(rise_en), .fall_en(fall_en),
    .ien(ien), .fen(fen), .presc(presc), .lim(lim)
  );

  xirq_tick #(.PRE_W(PRE_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .presc(presc), .tick(tick)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    xirq_chan #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .pin(ext_in[g]), .warm_done(warm_done),
      .tick(tick), .filt_en(fen[g]), .lim(lim[g]), .level(level_v[g]),
      .rise(rise_v[g]), .fall(fall_v[g])
    );
  end

  assign set_vec = warm_done ? ((rise_v & rise_en) | (fall_v & fall_en)) : '0;
  assign pend    = flags & ien;
  assign irq_out = {|pend[NCH-1:GRP0], |pend[GRP0-1:0]};
endmodule

// File: rtl/xirq_checker.sv
module xirq_checker #(
  parameter int NCH   = 14,
  parameter int GRP0  = 8,
  parameter int PRE_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   flags,
  input logic [NCH-1:0]   ien,
  input logic [NCH-1:0]   rise_en,
  input logic [NCH-1:0]   fall_en,
  input logic [NCH-1:0]   set_vec,
  input logic [NCH-1:0]   clr_vec,
  input logic             tick,
  input logic [PRE_W-1:0] presc,
  input logic [1:0]       irq_out
);
  // an edge event always leaves its flag set, even against a clear
  assert_set_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));

  // a flag only drops after a one was written to it
  assert_drop_needs_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((~flags & $past(flags) & ~$past(clr_vec)) == '0));

  // a line with no edge enabled never raises its flag
  assert_no_edge_no_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ~$past(flags) & ~($past(rise_en) | $past(fall_en))) == '0));

  assert_grp0_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out[0] |-> ((flags[GRP0-1:0] & ien[GRP0-1:0]) != '0));

  assert_grp1_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out[1] |-> ((flags[NCH-1:GRP0] & ien[NCH-1:GRP0]) != '0));

  // with a non-zero, steady prescaler, ticks never come back to back
  assert_tick_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && presc != '0) |=> (!tick || presc == '0 || !$stable(presc)));
endmodule

bind xirq_filter_ctrl xirq_checker #(.NCH(NCH), .GRP0(GRP0), .PRE_W(PRE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flags(flags), .ien(ien), .rise_en(rise_en),
  .fall_en(fall_en), .set_vec(set_vec), .clr_vec(clr_vec), .tick(tick),
  .presc(presc), .irq_out(irq_out)
);

// File: tb/xirq_filter_ctrl_tb.sv
`timescale 1ns/1ps
module xirq_filter_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] ext_in = 14'h0001;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = 5'd5;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  irq_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  xirq_filter_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [13:0] m_s1, m_s2, m_lvl, m_prv, m_re, m_fe, m_ien, m_fen, m_flags;
  int        m_run [14];
  int        m_lim [14];
  int        m_pc, m_pre, m_age;

  task automatic model_step();
    bit [13:0] setv, clr, n_lvl, n_prv;
    bit tk;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_lvl = 0; m_prv = 0; m_re = 0; m_fe = 0;
      m_ien = 0; m_fen = 0; m_flags = 0; m_pc = 0; m_pre = 0; m_age = 0;
      foreach (m_run[i]) begin m_run[i] = 0; m_lim[i] = 0; end
      return;
    end
    tk = (m_pc >= m_pre);
    setv = 0;
    for (int i = 0; i < 14; i++)
      if (m_age >= 3 && ((m_lvl[i] && !m_prv[i] && m_re[i]) ||
                         (!m_lvl[i] && m_prv[i] && m_fe[i]))) setv[i] = 1;
    clr = (reg_wr && reg_addr == 5) ? reg_wdata[13:0] : 14'h0;
    m_flags = (m_flags & ~clr) | setv;
    for (int i = 0; i < 14; i++) begin
      n_prv[i] = m_lvl[i];
      n_lvl[i] = m_lvl[i];
      if (m_age < 3) begin
        n_lvl[i] = m_s2[i]; n_prv[i] = m_s2[i]; m_run[i] = 0;
      end else if (!m_fen[i]) begin
        n_lvl[i] = m_s2[i]; m_run[i] = 0;
      end else if (tk) begin
        if (m_s2[i] == m_lvl[i]) m_run[i] = 0;
        else begin
          m_run[i]++;
          if (m_run[i] >= ((m_lim[i] == 0) ? 1 : m_lim[i])) begin
            n_lvl[i] = m_s2[i]; m_run[i] = 0;
          end
        end
      end
    end
    m_lvl = n_lvl; m_prv = n_prv; m_s2 = m_s1; m_s1 = ext_in;
    m_pc = tk ? 0 : m_pc + 1;
    if (m_age < 3) m_age++;
    if (reg_wr) begin
      case (reg_addr)
        5'd0: m_re  = reg_wdata[13:0];
        5'd1: m_fe  = reg_wdata[13:0];
        5'd2: m_ien = reg_wdata[13:0];
        5'd3: m_fen = reg_wdata[13:0];
        5'd4: m_pre = int'(reg_wdata[3:0]);
        default: if (reg_addr >= 8 && reg_addr < 22) m_lim[reg_addr-8] = int'(reg_wdata[3:0]);
      endcase
    end
  endtask

  always @(posedge clk) begin
    bit [1:0] exp_irq;
    model_step();
    #2;
    if (rst_n && !done) begin
      exp_irq = {|(m_flags[13:8] & m_ien[13:8]), |(m_flags[7:0] & m_ien[7:0])};
      check(irq_out == exp_irq, "R5 model irq", {30'b0, irq_out}, {30'b0, exp_irq});
      if (reg_addr == 5)
        check(reg_rdata == {18'b0, m_flags}, "R6 model flags", reg_rdata, {18'b0, m_flags});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_addr = 5; reg_wdata = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = 5;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1;
    idle(8);
    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      rd(a[4:0], v);
      check(v == 0, "R1 reset register", v, 0);
    end
    check(irq_out == 0, "R1 reset irq", {30'b0, irq_out}, 0);
    wr(0, 32'h3FFF); wr(1, 32'h3FFF);
    idle(6);
    rd(5, v); check(v == 0, "R1 no edge from reset level", v, 0);

    // R2/R3/R4 edge selection
    wr(0, 32'h000A); wr(1, 32'h000C); wr(2, 32'h3FFF);
    wr(5, 32'h3FFF);
    @(negedge clk) ext_in = ext_in | 14'h001E;
    idle(6);
    rd(5, v); check(v == 32'h000A, "R2 rising edges", v, 32'h000A);
    check(irq_out == 2'b01, "R5 group 0 request", {30'b0, irq_out}, 1);
    @(negedge clk) ext_in = ext_in & ~14'h001E;
    idle(6);
    rd(5, v); check(v == 32'h000E, "R3 falling and both", v, 32'h000E);
    check(v[4] == 1'b0, "R4 no edges enabled", {31'b0, v[4]}, 0);

    // R6 write-one-to-clear
    wr(5, 32'h0002); idle(1);
    rd(5, v); check(v == 32'h000C, "R6 clear one flag", v, 32'h000C);
    wr(5, 32'h0000); idle(1);
    rd(5, v); check(v == 32'h000C, "R6 zero write keeps flags", v, 32'h000C);

    // R5 request enable and second group
    wr(2, 32'h0200); idle(1);
    check(irq_out == 2'b00, "R5 masked flags", {30'b0, irq_out}, 0);
    wr(0, 32'h020A);
    @(negedge clk) ext_in[9] = 1;
    idle(6);
    rd(5, v); check(v == 32'h020C, "R5 line 9 flag", v, 32'h020C);
    check(irq_out == 2'b10, "R5 group 1 request", {30'b0, irq_out}, 2);
    wr(5, 32'h3FFF); idle(1);
    check(irq_out == 2'b00, "R6 all cleared", {30'b0, irq_out}, 0);

    // R2/R8 latency on raw synchronised input
    wr(0, 32'h0400);
    @(negedge clk) ext_in[10] = 1;
    idle(2);
    @(negedge clk) check(reg_rdata[10] == 1'b0, "R8 third edge clear", {31'b0, reg_rdata[10]}, 0);
    @(negedge clk) check(reg_rdata[10] == 1'b1, "R2 fourth edge set", {31'b0, reg_rdata[10]}, 1);
    wr(5, 32'h3FFF);

    // R7 set against clear in the same cycle
    wr(0, 32'h0020);
    @(negedge clk) ext_in[5] = 1;
    idle(2);
    @(negedge clk);
    reg_wr = 1; reg_addr = 5; reg_wdata = 32'h0020;
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0;
    idle(2);
    rd(5, v); check(v == 32'h0020, "R7 set beats clear", v, 32'h0020);
    wr(5, 32'h3FFF);

    // R9 glitch filter
    wr(4, 32'h0003); wr(14, 32'h0003); wr(3, 32'h0040); wr(0, 32'h0040); wr(1, 32'h0000);
    idle(4);
    @(negedge clk) ext_in[6] = 1; idle(7);
    ext_in[6] = 0; idle(4);
    ext_in[6] = 1; idle(7);
    ext_in[6] = 0; idle(20);
    rd(5, v); check(v == 0, "R9 short pulses rejected", v, 0);
    ext_in[6] = 1; idle(30);
    rd(5, v); check(v == 32'h0040, "R9 long level accepted", v, 32'h0040);
    wr(15, 32'h0000); wr(3, 32'h00C0); wr(0, 32'h00C0);
    idle(4);
    @(negedge clk) ext_in[7] = 1; idle(4);
    ext_in[7] = 0; idle(20);
    rd(5, v); check(v == 32'h00C0, "R9 limit zero acts as one", v, 32'h00C0);

    // R10 register map
    wr(4, 32'h00FF);
    rd(4, v); check(v == 32'h000F, "R10 prescaler width", v, 32'h000F);
    rd(14, v); check(v == 32'h0003, "R10 line 6 limit", v, 32'h0003);
    rd(0, v); check(v == 32'h00C0, "R10 rise enables", v, 32'h00C0);
    wr(2, 32'hFFFF_FFFF);
    rd(2, v); check(v == 32'h3FFF, "R10 request enable width", v, 32'h3FFF);
    rd(31, v); check(v == 0, "R10 unmapped address", v, 0);

    idle(4);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule